// File: doc/BRIEF.md
# Delayed-Branch Five-Stage Integer Core

This block is a small in-order 32-bit processor that runs a reduced load/store integer instruction set. Its pipeline has five stages: fetch, decode with register read, execute, memory, and register write back. It takes one instruction into fetch on every clock. Conditional branches and jumps are resolved in decode. As a result, the instruction fetched right after a control transfer (its delay slot) always runs. No instruction is ever squashed.

The core has no operand forwarding and no interlock, and it never stalls. The program itself must leave at least two instructions between a result and any use of it. Loads follow the same rule. Instruction memory and data memory are attached through two plain ports, each read combinationally. A separate read port into the register file lets a test environment or system observe architectural state.

Top module: `dsc_core`

## Requirements
- R1: While reset is asserted, the fetch address equals RESET_PC (default 0) and the data write strobe is low. After reset every register reads zero through the debug port.
- R2: When no control transfer is resolved in decode, the fetch address advances by 4 on every clock, with no stall cycles.
- R3: A branch-if-equal (opcode 6'h04, rs in bits 25:21, rt in bits 20:16, signed word offset in bits 15:0) whose two registers are equal still runs the next sequential instruction. Fetch then continues at branch address + 4 + (sign-extended offset << 2).
- R4: A branch-if-equal whose registers differ runs its delay slot and then continues sequentially.
- R5: A jump (opcode 6'h02, index in bits 25:0) runs its delay slot. Fetch then continues at {upper 4 bits of jump address + 4, index, 2'b00}, and the instructions it skips have no effect.
- R6: No operand forwarding is done. An instruction three or more slots after a producer reads the new value, because a write back and a decode read in the same clock see the written data. An instruction one or two slots after the producer reads the old value.
- R7: The core supports three arithmetic forms. Add-immediate (opcode 6'h08) sets rt to rs + sign-extended bits 15:0. Register add (opcode 0, function 6'h20) sets rd (bits 15:11) to rs + rt. Shift-left (opcode 0, function 6'h00) sets rd to rt shifted left by bits 10:6. An all-zero word changes nothing.
- R8: A load (opcode 6'h23) writes the data word at rs + sign-extended offset into rt. A store (opcode 6'h2b) drives that address, the value of rt, and a one-clock write strobe in its memory clock, three clocks after its fetch clock.
- R9: Register 0 always reads zero. Writes to it are discarded.
- R10: Take a ten-instruction if/else sequence whose branch is followed by a jump, each with a filled delay slot, and whose final instruction is a store. Counting the first fetch as clock 1, the final store reaches the data port in clock 11 on the taken path, so it retires in clock 12. On the not-taken path it reaches the port in clock 12 and retires in clock 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, same clock |
| dmem_addr | output | 32 | Byte address of the load or store in the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one clock per store |
| dmem_rdata | input | 32 | Data word at dmem_addr, same clock |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Content of the selected register |

## Verification
Two events can fall in the same clock: a write back to a register and the decode-stage read of that same register by the instruction three slots behind. The sequence tests provoke this with a producer followed by consumers at distances one, two and three. It is judged by the values the consumers leave behind: old, old, then new. The branch tests create the same collision on control flow. There, a branch resolves in decode while its delay slot is being fetched in the same clock. Each store is checked for address, data and exact clock, so the check shows both that the slot ran and that the skipped instructions did nothing.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam int SHW  = $clog2(XLEN);

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2b;

  localparam logic [5:0] FN_SHL = 6'h00;
  localparam logic [5:0] FN_ADD = 6'h20;

  typedef enum logic [0:0] {
    ALU_ADD = 1'b0,
    ALU_SHL = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic            reg_we;
    logic [RIDX-1:0] wsel;
    logic            mem_re;
    logic            mem_we;
    alu_op_e         alu;
  } ctrl_t;

  typedef struct packed {
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] pc4;
  } ifid_t;

  typedef struct packed {
    ctrl_t           c;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] st;
  } idex_t;

  typedef struct packed {
    logic            reg_we;
    logic [RIDX-1:0] wsel;
    logic            mem_re;
    logic            mem_we;
    logic [XLEN-1:0] res;
    logic [XLEN-1:0] st;
  } exmem_t;

  typedef struct packed {
    logic            we;
    logic [RIDX-1:0] wsel;
    logic [XLEN-1:0] data;
  } memwb_t;

endpackage

// File: rtl/dsc_regfile.sv
module dsc_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2,
  input  logic [AW-1:0] dbg_a,
  output logic [DW-1:0] dbg_d
);

  localparam int NREG = 1 << AW;

  logic [NREG*DW-1:0] flat;

  // entry 0 is a hard zero; the rest are flops with a write enable
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign flat[0 +: DW] = '0;
    end else begin : g_live
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (we && (waddr == AW'(g))) begin
          q <= wdata;
        end
      end
      assign flat[g*DW +: DW] = q;
    end
  end

  // write-first: a write back in this clock is visible to decode now
  always_comb begin
    if (we && (waddr != '0) && (waddr == ra1)) rd1 = wdata;
    else                                       rd1 = flat[ra1*DW +: DW];
    if (we && (waddr != '0) && (waddr == ra2)) rd2 = wdata;
    else                                       rd2 = flat[ra2*DW +: DW];
    dbg_d = flat[dbg_a*DW +: DW];
  end

endmodule

// File: rtl/dsc_decode.sv
module dsc_decode
  import dsc_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] pc4,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic [RIDX-1:0] rs_idx,
  output logic [RIDX-1:0] rt_idx,
  output ctrl_t           ctrl,
  output logic [XLEN-1:0] op_a,
  output logic [XLEN-1:0] op_b,
  output logic [XLEN-1:0] st_data,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc
);

  logic [5:0]      opc;
  logic [5:0]      fn;
  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] j_tgt;
  logic            is_beq;
  logic            is_j;

  always_comb begin
    opc     = instr[31:26];
    fn      = instr[5:0];
    rs_idx  = instr[25:21];
    rt_idx  = instr[20:16];
    imm_sx  = {{16{instr[15]}}, instr[15:0]};
    br_tgt  = pc4 + (imm_sx << 2);
    j_tgt   = {pc4[31:28], instr[25:0], 2'b00};

    ctrl    = '0;
    op_a    = rs_val;
    op_b    = imm_sx;
    st_data = rt_val;
    is_beq  = 1'b0;
    is_j    = 1'b0;

    case (opc)
      OPC_RTYPE: begin
        if (fn == FN_ADD) begin
          ctrl.reg_we = 1'b1;
          ctrl.wsel   = instr[15:11];
          ctrl.alu    = ALU_ADD;
          op_b        = rt_val;
        end else if (fn == FN_SHL) begin
          ctrl.reg_we = 1'b1;
          ctrl.wsel   = instr[15:11];
          ctrl.alu    = ALU_SHL;
          op_a        = rt_val;
          op_b        = {{(XLEN-5){1'b0}}, instr[10:6]};
        end
      end
      OPC_ADDI: begin
        ctrl.reg_we = 1'b1;
        ctrl.wsel   = rt_idx;
      end
      OPC_LOAD: begin
        ctrl.reg_we = 1'b1;
        ctrl.wsel   = rt_idx;
        ctrl.mem_re = 1'b1;
      end
      OPC_STORE: begin
        ctrl.mem_we = 1'b1;
      end
      OPC_BEQ:  is_beq = 1'b1;
      OPC_JUMP: is_j   = 1'b1;
      default: ;
    endcase

    redirect    = is_j | (is_beq & (rs_val == rt_val));
    redirect_pc = is_j ? j_tgt : br_tgt;
  end

endmodule

// File: rtl/dsc_alu.sv
module dsc_alu
  import dsc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  always_comb begin
    case (op)
      ALU_SHL: y = a << b[SHW-1:0];
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/dsc_core.sv
module dsc_core
  import dsc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  input  logic [4:0]  dbg_sel,
  output logic [31:0] dbg_data
);

  logic [XLEN-1:0] pc_q, pc_d;
  ifid_t           ifid_q, ifid_d;
  idex_t           idex_q, idex_d;
  exmem_t          exmem_q, exmem_d;
  memwb_t          memwb_q, memwb_d;

  logic [XLEN-1:0] id_instr;
  logic [RIDX-1:0] rs_idx, rt_idx;
  logic [XLEN-1:0] rs_val, rt_val;
  ctrl_t           dec_ctrl;
  logic [XLEN-1:0] dec_a, dec_b, dec_st;
  logic            redirect;
  logic [XLEN-1:0] redirect_pc;
  logic [XLEN-1:0] alu_y;
  logic            mem_is_load;
  logic            rf_we;
  logic [RIDX-1:0] rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  assign id_instr    = ifid_q.instr;
  assign mem_is_load = exmem_q.mem_re;
  assign rf_we       = memwb_q.we;
  assign rf_waddr    = memwb_q.wsel;
  assign rf_wdata    = memwb_q.data;

  dsc_regfile #(.DW(XLEN), .AW(RIDX)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra1   (rs_idx),
    .ra2   (rt_idx),
    .rd1   (rs_val),
    .rd2   (rt_val),
    .dbg_a (dbg_sel),
    .dbg_d (dbg_data)
  );

  dsc_decode u_dec (
    .instr       (id_instr),
    .pc4         (ifid_q.pc4),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .rs_idx      (rs_idx),
    .rt_idx      (rt_idx),
    .ctrl        (dec_ctrl),
    .op_a        (dec_a),
    .op_b        (dec_b),
    .st_data     (dec_st),
    .redirect    (redirect),
    .redirect_pc (redirect_pc)
  );

  dsc_alu u_alu (
    .op (idex_q.c.alu),
    .a  (idex_q.a),
    .b  (idex_q.b),
    .y  (alu_y)
  );

  // next-state for every stage; nothing is ever squashed or held
  always_comb begin
    pc_d          = redirect ? redirect_pc : pc_q + 32'd4;

    ifid_d.instr  = imem_rdata;
    ifid_d.pc4    = pc_q + 32'd4;

    idex_d.c      = dec_ctrl;
    idex_d.a      = dec_a;
    idex_d.b      = dec_b;
    idex_d.st     = dec_st;

    exmem_d.reg_we = idex_q.c.reg_we;
    exmem_d.wsel   = idex_q.c.wsel;
    exmem_d.mem_re = idex_q.c.mem_re;
    exmem_d.mem_we = idex_q.c.mem_we;
    exmem_d.res    = alu_y;
    exmem_d.st     = idex_q.st;

    memwb_d.we    = exmem_q.reg_we;
    memwb_d.wsel  = exmem_q.wsel;
    memwb_d.data  = mem_is_load ? dmem_rdata : exmem_q.res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      pc_q    <= pc_d;
      ifid_q  <= ifid_d;
      idex_q  <= idex_d;
      exmem_q <= exmem_d;
      memwb_q <= memwb_d;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = exmem_q.res;
  assign dmem_wdata = exmem_q.st;
  assign dmem_we    = exmem_q.mem_we;

endmodule

// File: rtl/dsc_core_chk.sv
module dsc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic [31:0] id_instr,
  input logic        redirect,
  input logic [31:0] redirect_pc,
  input logic        wb_we,
  input logic [4:0]  wb_sel,
  input logic [31:0] wb_data,
  input logic [4:0]  rs_idx,
  input logic [31:0] rs_val,
  input logic        dmem_we,
  input logic        mem_is_load,
  input logic [4:0]  dbg_sel,
  input logic [31:0] dbg_data
);

  assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> imem_addr == $past(imem_addr) + 32'd4);

  // covers the taken branch (R3) and the jump (R5)
  assert_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> imem_addr == $past(redirect_pc));

  assert_slot_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> id_instr == $past(imem_rdata));

  assert_wb_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && wb_sel != 5'd0 && wb_sel == rs_idx) |-> rs_val == wb_data);

  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_sel == 5'd0 |-> dbg_data == 32'd0);

  assert_mem_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> !mem_is_load);

endmodule

bind dsc_core dsc_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .imem_addr   (imem_addr),
  .imem_rdata  (imem_rdata),
  .id_instr    (id_instr),
  .redirect    (redirect),
  .redirect_pc (redirect_pc),
  .wb_we       (rf_we),
  .wb_sel      (rf_waddr),
  .wb_data     (rf_wdata),
  .rs_idx      (rs_idx),
  .rs_val      (rs_val),
  .dmem_we     (dmem_we),
  .mem_is_load (mem_is_load),
  .dbg_sel     (dbg_sel),
  .dbg_data    (dbg_data)
);

// File: tb/dsc_core_test.sv
`timescale 1ns/1ps
module dsc_core_test;

  localparam logic [5:0] T_ADDI = 6'h08;
  localparam logic [5:0] T_LW   = 6'h23;
  localparam logic [5:0] T_SW   = 6'h2b;
  localparam logic [5:0] T_BEQ  = 6'h04;
  localparam logic [5:0] T_FADD = 6'h20;
  localparam logic [5:0] T_FSHL = 6'h00;

  logic        clk;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [4:0]  dbg_sel;
  logic [31:0] dbg_data;

  logic [31:0] im [256];
  logic [31:0] dm [256];
  int          cyc;
  int          n_chk;
  int          n_bad;

  logic [31:0] qa [$];
  logic [31:0] qd [$];
  int          qc [$];
  string       qt [$];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  dsc_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata),
    .dbg_sel    (dbg_sel),
    .dbg_data   (dbg_data)
  );

  assign imem_rdata = im[imem_addr[9:2]];
  assign dmem_rdata = dm[dmem_addr[9:2]];

  always @(posedge clk) begin
    if (dmem_we) dm[dmem_addr[9:2]] = dmem_wdata;
  end

  // clock 1 is the clock in which the first instruction is fetched
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 1;
    else        cyc <= cyc + 1;
  end

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
  endfunction

  function automatic logic [31:0] enc_j(int idx);
    return {6'h02, idx[25:0]};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic exp_store(logic [31:0] a, logic [31:0] d, int c, string t);
    qa.push_back(a);
    qd.push_back(d);
    qc.push_back(c);
    qt.push_back(t);
  endtask

  // scoreboard monitor: every store on the port is matched in order
  always @(negedge clk) begin : mon
    logic [31:0] ea, ed;
    int          ec;
    string       et;
    if (rst_n && dmem_we) begin
      if (qa.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R5/R8 unexpected store: actual %h<-%h expected none",
                 dmem_addr, dmem_wdata);
      end else begin
        ea = qa.pop_front();
        ed = qd.pop_front();
        ec = qc.pop_front();
        et = qt.pop_front();
        check(et, "store addr", dmem_addr, ea);
        check(et, "store data", dmem_wdata, ed);
        check(et, "store clock", cyc, ec);
      end
    end
  end

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 256; k++) begin
      im[k] = 32'd0;
      dm[k] = 32'd0;
    end
  endtask

  task automatic leave_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic to_cycle(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic rdreg(int r, logic [31:0] e, string t);
    @(negedge clk);
    dbg_sel = r[4:0];
    #1;
    check(t, $sformatf("reg %0d", r), dbg_data, e);
  endtask

  task automatic drain(string t);
    check(t, "stores still pending", 32'(qa.size()), 32'd0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic load_ifelse();
    dm[8'h10] = 32'd7;                      // a at 0x40
    im[0] = enc_i(T_LW, 0, 1, 32'h40);
    im[1] = enc_i(T_LW, 0, 2, 32'h44);
    im[2] = enc_i(T_ADDI, 0, 4, 4);
    im[3] = enc_i(T_ADDI, 0, 3, 3);
    im[4] = enc_i(T_BEQ, 1, 2, 3);          // to index 8
    im[5] = enc_i(T_ADDI, 0, 5, 5);         // branch slot
    im[6] = enc_j(9);
    im[7] = enc_i(T_SW, 0, 4, 32'h48);      // jump slot
    im[8] = enc_i(T_SW, 0, 3, 32'h48);
    im[9] = enc_i(T_SW, 0, 3, 32'h4c);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    n_chk   = 0;
    n_bad   = 0;
    rst_n   = 1'b0;
    dbg_sel = 5'd0;

    // ---- arithmetic, hazard spacing and register zero
    enter_reset();
    im[0] = enc_i(T_ADDI, 0, 1, 5);
    im[1] = enc_i(T_ADDI, 1, 2, 1);         // one slot after: old
    im[2] = enc_i(T_ADDI, 1, 3, 2);         // two slots after: old
    im[3] = enc_i(T_ADDI, 1, 4, 3);         // three slots after: new
    im[4] = enc_i(T_ADDI, 0, 0, 9);
    im[5] = enc_i(T_ADDI, 0, 6, -3);
    im[6] = enc_r(0, 4, 5, 4, T_FSHL);
    im[7] = enc_i(T_ADDI, 0, 9, 32'h7fff);
    im[8] = enc_r(4, 6, 7, 0, T_FADD);
    im[9] = enc_i(T_ADDI, 0, 8, 1);
    leave_reset();
    to_cycle(2);
    check("R2", "fetch addr clk2", imem_addr, 32'h4);
    to_cycle(5);
    check("R2", "fetch addr clk5", imem_addr, 32'h10);
    to_cycle(25);
    rdreg(1, 32'd5, "R7");
    rdreg(2, 32'd1, "R6");
    rdreg(3, 32'd2, "R6");
    rdreg(4, 32'd8, "R6");
    rdreg(0, 32'd0, "R9");
    rdreg(8, 32'd1, "R9");
    rdreg(6, 32'hffff_fffd, "R7");
    rdreg(5, 32'h80, "R7");
    rdreg(7, 32'd5, "R7");
    rdreg(9, 32'h7fff, "R7");

    // ---- reset state
    enter_reset();
    #1;
    check("R1", "fetch addr in reset", imem_addr, 32'h0);
    check("R1", "store strobe in reset", 32'(dmem_we), 32'd0);
    rdreg(1, 32'd0, "R1");
    rdreg(7, 32'd0, "R1");

    // ---- loads and stores with signed offsets
    dm[8'h1f] = 32'h1234_5678;              // word at 0x7c
    im[0] = enc_i(T_ADDI, 0, 1, 32'h80);
    im[3] = enc_i(T_LW, 1, 2, -4);
    im[4] = enc_i(T_SW, 1, 1, 8);
    im[7] = enc_i(T_SW, 1, 2, 0);
    im[8] = enc_i(T_ADDI, 2, 3, 1);
    exp_store(32'h88, 32'h80, 8, "R8");
    exp_store(32'h80, 32'h1234_5678, 11, "R8");
    leave_reset();
    to_cycle(25);
    drain("R8");
    rdreg(2, 32'h1234_5678, "R8");
    rdreg(3, 32'h1234_5679, "R8");

    // ---- if/else, branch taken
    enter_reset();
    load_ifelse();
    dm[8'h11] = 32'd7;                      // b equal to a
    exp_store(32'h48, 32'd3, 10, "R3");
    exp_store(32'h4c, 32'd3, 11, "R10");
    leave_reset();
    to_cycle(6);
    check("R3", "slot fetch addr", imem_addr, 32'h14);
    to_cycle(7);
    check("R3", "branch target fetch", imem_addr, 32'h20);
    to_cycle(25);
    drain("R10");
    rdreg(5, 32'd5, "R3");

    // ---- if/else, branch not taken
    enter_reset();
    load_ifelse();
    dm[8'h11] = 32'd9;                      // b differs from a
    exp_store(32'h48, 32'd4, 11, "R5");
    exp_store(32'h4c, 32'd3, 12, "R10");
    leave_reset();
    to_cycle(7);
    check("R4", "fall-through fetch", imem_addr, 32'h18);
    to_cycle(8);
    check("R5", "jump slot fetch", imem_addr, 32'h1c);
    to_cycle(9);
    check("R5", "jump target fetch", imem_addr, 32'h24);
    to_cycle(25);
    drain("R10");
    rdreg(5, 32'd5, "R4");

    summary();
    $finish;
  end

endmodule